// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches several ports of input pins and raises one interrupt request per port group whenever any selected pin in that group changes level. Each group has its own pin-select mask. Any toggle of a selected pin, rising or falling, marks the group's pending flag. The block cannot select an edge direction and does not produce interrupt vectors. Changes on pins that are not selected are ignored.

Software programs the block over a simple synchronous register port. It writes the per-group enables and masks, reads any register back, and acknowledges a pending group by writing a one to that group's flag bit. A group's request output is high whenever its flag is pending and its enable is set. A flag is recorded even while its group is disabled, so enabling the group later asserts the request straight away.

Top module: `pcic_top`

## Requirements
- R1: After a synchronous reset, all flags, enables and masks are zero, `irq_o` is zero, and `rd_data_o` reads zero.
- R2: A rising level on a pin whose mask bit is 1 sets that group's flag on the next clock edge.
- R3: A falling level on a pin whose mask bit is 1 also sets that group's flag on the next clock edge.
- R4: A level change on a pin whose mask bit is 0 leaves that group's flag unchanged.
- R5: Writing the flag register (address 1) clears every group flag whose data bit g is 1. Flags whose data bit is 0 are left unchanged.
- R6: `irq_o[g]` equals flag g AND enable g, and updates on the same edge as the flag or enable register. A flag set while its group is disabled raises `irq_o[g]` on the edge that writes the enable bit.
- R7: If a pin-change event and a flag-clear write for the same group occur in the same cycle, the flag ends up set.
- R8: Group g owns bit g of the enable and flag registers and watches pins `pins_i[g*PORT_W +: PORT_W]`. An event in one group changes no other group's flag.
- R9: The register map is: address 0 is the enable register (bits g), address 1 is the flag register, and address 2+g is group g's mask. Reading address A returns that register's value in `rd_data_o` one clock after A is presented. Unmapped addresses read zero.
- R10: Pin levels present when reset is released are taken as the starting reference, so they do not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_GROUPS*PORT_W | Current pin levels; group g uses slice g*PORT_W +: PORT_W |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for write and read |
| wr_data_i | input | PORT_W | Register write data |
| rd_data_o | output | PORT_W | Registered read data for the address of the previous cycle |
| irq_o | output | NUM_GROUPS | Registered per-group interrupt request |

## Verification
The bench uses the default parameters: three groups of eight pins and a 3-bit address. With these values every group bit is exercised, including the highest flag bit. The top mask address (4) is exercised as well, and an unmapped address is also in range. These settings cover the cross-group isolation and same-cycle set-versus-clear cases on the outermost group, where an indexing slip would show first.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  localparam int unsigned ADDR_ENABLE = 0;
  localparam int unsigned ADDR_FLAG   = 1;
  localparam int unsigned ADDR_MASK0  = 2;
endpackage

// File: rtl/pcic_change_det.sv
module pcic_change_det #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins_i,
  input  logic [PORT_W-1:0] mask_i,
  output logic              hit_o
);
  logic [PORT_W-1:0] prev_q;

  // Reference level follows the pins; reset loads the present levels (R10)
  always_ff @(posedge clk) begin
    prev_q <= pins_i;
  end

  assign hit_o = |((pins_i ^ prev_q) & mask_i) & ~rst;
endmodule

// File: rtl/pcic_flag_bank.sv
module pcic_flag_bank #(
  parameter int unsigned NUM_GROUPS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_GROUPS-1:0] set_i,
  input  logic [NUM_GROUPS-1:0] clr_i,
  output logic [NUM_GROUPS-1:0] flag_q,
  output logic [NUM_GROUPS-1:0] flag_d
);
  // Set has priority over a same-cycle acknowledge
  assign flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flag_q[g]);
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[g] && flag_q[g]) |=> flag_q[g]);
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
      (!set_i[g] && !flag_q[g]) |=> !flag_q[g]);
  end
endmodule

// File: rtl/pcic_regs.sv
module pcic_regs
  import pcic_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [PORT_W-1:0]            wr_data_i,
  input  logic [NUM_GROUPS-1:0]        flag_q_i,
  output logic [NUM_GROUPS-1:0]        en_q,
  output logic [NUM_GROUPS-1:0]        en_d,
  output logic [NUM_GROUPS*PORT_W-1:0] mask_o,
  output logic [NUM_GROUPS-1:0]        clr_o,
  output logic [PORT_W-1:0]            rd_data_o
);
  logic wr_enable, wr_flag;
  logic [PORT_W-1:0] rd_next;

  assign wr_enable = wr_en_i && (addr_i == ADDR_W'(ADDR_ENABLE));
  assign wr_flag   = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAG));
  assign clr_o     = wr_flag ? wr_data_i[NUM_GROUPS-1:0] : '0;
  assign en_d      = wr_enable ? wr_data_i[NUM_GROUPS-1:0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    logic [PORT_W-1:0] mask_q;
    always_ff @(posedge clk) begin
      if (rst)
        mask_q <= '0;
      else if (wr_en_i && (addr_i == ADDR_W'(ADDR_MASK0 + g)))
        mask_q <= wr_data_i;
    end
    assign mask_o[g*PORT_W +: PORT_W] = mask_q;
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(ADDR_ENABLE)) rd_next[NUM_GROUPS-1:0] = en_q;
    if (addr_i == ADDR_W'(ADDR_FLAG))   rd_next[NUM_GROUPS-1:0] = flag_q_i;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (addr_i == ADDR_W'(ADDR_MASK0 + g)) rd_next = mask_o[g*PORT_W +: PORT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end
endmodule

// File: rtl/pcic_top.sv
module pcic_top #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_GROUPS*PORT_W-1:0] pins_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [PORT_W-1:0]            wr_data_i,
  output logic [PORT_W-1:0]            rd_data_o,
  output logic [NUM_GROUPS-1:0]        irq_o
);
  logic [NUM_GROUPS-1:0]        hit, clr, flag_q, flag_d, en_q, en_d;
  logic [NUM_GROUPS*PORT_W-1:0] mask;

  pcic_regs #(.NUM_GROUPS(NUM_GROUPS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
    .flag_q_i(flag_q), .en_q(en_q), .en_d(en_d), .mask_o(mask), .clr_o(clr),
    .rd_data_o(rd_data_o)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_port
    pcic_change_det #(.PORT_W(PORT_W)) i_det (
      .clk(clk), .rst(rst),
      .pins_i(pins_i[g*PORT_W +: PORT_W]),
      .mask_i(mask[g*PORT_W +: PORT_W]),
      .hit_o(hit[g])
    );
  end

  pcic_flag_bank #(.NUM_GROUPS(NUM_GROUPS)) i_flags (
    .clk(clk), .rst(rst), .set_i(hit), .clr_i(clr), .flag_q(flag_q), .flag_d(flag_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= flag_d & en_d;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (irq_o == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
      irq_o[g] |-> (en_q[g] && flag_q[g]));
    p_irq_raise_r6: assert property (@(posedge clk) disable iff (rst)
      (en_q[g] && flag_q[g]) |-> irq_o[g]);
  end
endmodule

// File: tb/test_pcic_top.sv
module test_pcic_top;
  localparam int NG = 3;
  localparam int PW = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NG*PW-1:0] pins = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] wdata = '0;
  logic [PW-1:0] rdata;
  logic [NG-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcic_top #(.NUM_GROUPS(NG), .PORT_W(PW), .ADDR_W(AW)) i_pcic_top (
    .clk(clk), .rst(rst), .pins_i(pins), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = PW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic set_pin(input int g, input int b, input logic v);
    @(negedge clk);
    pins[g*PW + b] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int d;
    pins = 24'h00_00_A5;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 rdata in reset", int'(rdata), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    rd(1, d); chk("R10 no flag from reset levels", d, 0);
    rd(0, d); chk("R1 enable zero", d, 0);
    for (int g = 0; g < NG; g++) begin
      rd(2 + g, d); chk("R1 mask zero", d, 0);
    end
    chk("R1 irq zero", int'(irq), 0);
  endtask

  task automatic t_rise_fall();
    int d;
    wr(2, 8'h02);
    wr(0, 3'b001);
    set_pin(0, 1, 1'b1);
    chk("R2 rising sets irq", int'(irq), 1);
    rd(1, d); chk("R2 rising sets flag", d, 1);
    wr(1, 3'b001);
    chk("R5 ack clears irq", int'(irq), 0);
    rd(1, d); chk("R5 ack clears flag", d, 0);
    set_pin(0, 1, 1'b0);
    chk("R3 falling sets irq", int'(irq), 1);
    wr(1, 3'b001);
    chk("R5 ack after fall", int'(irq), 0);
  endtask

  task automatic t_unmasked();
    int d;
    set_pin(0, 3, 1'b1);
    rd(1, d); chk("R4 unmasked port0 pin", d, 0);
    set_pin(1, 6, 1'b1);
    rd(1, d); chk("R4 unmasked port1 pin", d, 0);
    chk("R4 no irq", int'(irq), 0);
  endtask

  task automatic t_groups();
    int d;
    wr(4, 8'h80);
    set_pin(2, 7, 1'b1);
    rd(1, d); chk("R8 only group2 flag", d, 3'b100);
    chk("R6 disabled group no irq", int'(irq), 0);
    wr(0, 3'b101);
    chk("R6 enable raises pending irq", int'(irq), 3'b100);
    wr(1, 3'b011);
    rd(1, d); chk("R5 zero bit keeps flag", d, 3'b100);
    wr(1, 3'b100);
    rd(1, d); chk("R5 one bit clears flag", d, 0);
    chk("R6 irq drops with flag", int'(irq), 0);
  endtask

  task automatic t_set_wins();
    int d;
    wr(1, 3'b111);
    @(negedge clk);
    pins[2*PW + 7] = 1'b0;
    wr_en = 1'b1; addr = AW'(1); wdata = PW'(3'b100);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 set beats clear irq", int'(irq), 3'b100);
    rd(1, d); chk("R7 set beats clear flag", d, 3'b100);
    wr(1, 3'b100);
  endtask

  task automatic t_readback();
    int d;
    wr(3, 8'h5A);
    rd(3, d); chk("R9 mask1 readback", d, 8'h5A);
    rd(4, d); chk("R9 mask2 readback", d, 8'h80);
    rd(0, d); chk("R9 enable readback", d, 3'b101);
    rd(6, d); chk("R9 unmapped reads zero", d, 0);
    set_pin(1, 1, 1'b1);
    rd(1, d); chk("R8 group1 flag via new mask", d, 3'b010);
    chk("R6 group1 disabled", int'(irq), 0);
  endtask

  initial begin
    t_reset();
    t_rise_fall();
    t_unmasked();
    t_groups();
    t_set_wins();
    t_readback();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule